// File: doc/BRIEF.md
# SMBus Indexed Block-Access Configuration Register Target

This block is an SMBus target that gives a host access to a bank of eight 8-bit configuration registers. Every transfer is indexed. To write, the host addresses the target, sends a starting register index and a byte count, and then streams data bytes into consecutive registers. To read, the host sends the starting index, issues a repeated start with the read direction, and receives a byte-count byte followed by consecutive register contents. It keeps reading until it answers a byte with NACK.

Bus lines enter through a two-flop synchronizer and are sampled by a system clock that runs much faster than SCL. The target pulls SDA low only in its acknowledge slots and on the zero bits of the read data it sends. A strap chooses the bus address and a tri-level strap sets the default spread-spectrum setting. Both straps are captured while reset is asserted. The register contents are decoded into output fields for the surrounding clock logic.

Top module: `smb_cfg_target`

## Requirements
- R1: A write transfer consists of an address byte with R/W=0, an index byte N and a count byte X, followed by data bytes. The target ACKs every byte. Data byte k (starting at 0) is stored in register N+k only while k < X. Data bytes after the X-th are ACKed but change nothing.
- R2: A read transfer consists of an address byte with R/W=0 and an index byte N, then a repeated start and the address with R/W=1. The first byte the target returns is {3'b000, reg7[4:0]}. The bytes after it are the contents of registers N, N+1, and so on.
- R3: The target sends the next byte only when the host ACKs the previous one. After a host NACK, SDA stays released until the next start condition.
- R4: The register index is taken modulo 8. Both the low three bits of the index byte and the auto-incremented pointer wrap from register 7 to register 0.
- R5: The 7-bit bus address is 0x68 when `addr_sel` is low during reset and 0x6A when it is high. The value latched at reset applies until the next reset. A non-matching address byte is not ACKed, and the rest of that transfer has no effect.
- R6: The reset contents are reg0=0xFF, reg1={strap code, 6'b000110}, reg2=0xFF, reg3=0xDF, reg4=0xFF, reg5=0x01, reg6=0x02 and reg7=0x08.
- R7: Only these bits are writable: reg0[3:2], reg1[5:3], reg1[1:0], reg2[2:1], reg3[7:4] and reg7[4:0]. Writes to any other bit, including every bit of reg4, reg5 and reg6, are ACKed and leave the bit unchanged.
- R8: The field outputs follow the register contents as follows. `dif_oe` is reg0[3:2]. `amp_sel` is reg1[1:0]. `dif_slew` is reg2[2:1]. `ref_slew` is reg3[7:6]. `ref_wake_en` is reg3[5]. `ref_oe` is reg3[4]. A field changes only when a write stores a new value into it.
- R9: `ss_strap` is latched during reset: 0 means low, 1 means mid, and 2 or 3 mean high. reg1[7:6] reads back the strap code: 00 for low, 01 for mid, 11 for high. `ss_mode` equals reg1[4:3] when reg1[5]=1 and equals the strap code otherwise. A change of `ss_strap` after reset has no effect.
- R10: The target never pulls SDA low while the host is driving address, index, count, write-data or acknowledge bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset; straps are captured while it is high |
| scl_i | input | 1 | SMBus clock line level |
| sda_i | input | 1 | SMBus data line level |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| addr_sel | input | 1 | Address strap: 0 selects 0x68, 1 selects 0x6A |
| ss_strap | input | 2 | Tri-level spread strap: 0 low, 1 mid, 2 or 3 high |
| dif_oe | output | 2 | Differential output enables (reg0[3:2]) |
| amp_sel | output | 2 | Output amplitude select (reg1[1:0]) |
| dif_slew | output | 2 | Differential slew selects (reg2[2:1]) |
| ref_slew | output | 2 | Reference output slew select (reg3[7:6]) |
| ref_wake_en | output | 1 | Reference keeps running in power-down (reg3[5]) |
| ref_oe | output | 1 | Reference output enable (reg3[4]) |
| ss_mode | output | 2 | Effective spread mode: 00 off, 01 -0.25%, 10 reserved, 11 -0.5% |

## Verification
The checks on when SDA may change rest on two assumptions about the host. It changes SDA only while SCL is low, except for start and stop conditions. It holds every SCL phase for several system clocks, so that a synchronized edge reaches the state machine before the next edge of either line. The stimulus keeps SCL low and high for eight clocks each and moves SDA four clocks into the low phase. A bit driven by the target is therefore settled well before the host samples it at mid-high. The straps change only while reset is asserted, or deliberately afterwards to show that later changes have no effect. The register-field properties assume that reset is held for more than one clock.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

    localparam int NREG  = 8;
    localparam int IDX_W = $clog2(NREG);

    localparam int IDX_OE   = 0;
    localparam int IDX_SS   = 1;
    localparam int IDX_DSLW = 2;
    localparam int IDX_REF  = 3;
    localparam int IDX_CNT  = 7;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_ACK,
        PH_TX,
        PH_HACK
    } phase_e;

    typedef enum logic [1:0] {
        BK_ADDR,
        BK_INDEX,
        BK_COUNT,
        BK_DATA
    } kind_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic [1:0] dif_oe;
        logic [1:0] amp;
        logic [1:0] dif_slew;
        logic [1:0] ref_slew;
        logic       ref_wake;
        logic       ref_oe;
        logic [1:0] ss_mode;
    } cfg_out_t;

    function automatic logic [1:0] strap_code(input logic [1:0] lvl);
        case (lvl)
            2'd0:    return 2'b00;
            2'd1:    return 2'b01;
            default: return 2'b11;
        endcase
    endfunction

    function automatic logic [7:0] reg_rst(input int idx);
        case (idx)
            0:       return 8'hFF;
            1:       return 8'h06;
            2:       return 8'hFF;
            3:       return 8'hDF;
            4:       return 8'hFF;
            5:       return 8'h01;
            6:       return 8'h02;
            7:       return 8'h08;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] reg_wmask(input int idx);
        case (idx)
            0:       return 8'h0C;
            1:       return 8'h3B;
            2:       return 8'h06;
            3:       return 8'hF0;
            7:       return 8'h1F;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync
    import smb_cfg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    localparam int NLINE = 2;

    logic [NLINE-1:0] raw;
    logic [NLINE-1:0] cur;
    logic [NLINE-1:0] prev;

    assign raw = {scl_i, sda_i};

    for (genvar l = 0; l < NLINE; l++) begin : g_line
        logic [STAGES-1:0] chain;
        logic              last;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '1;
                last  <= 1'b1;
            end else begin
                chain <= {chain[STAGES-2:0], raw[l]};
                last  <= chain[STAGES-1];
            end
        end

        assign cur[l]  = chain[STAGES-1];
        assign prev[l] = last;
    end

    always_comb begin
        ev.sda      = cur[0];
        ev.scl_rise = cur[1] & ~prev[1];
        ev.scl_fall = ~cur[1] & prev[1];
        ev.start    = cur[1] & prev[1] & prev[0] & ~cur[0];
        ev.stop     = cur[1] & prev[1] & ~prev[0] & cur[0];
    end

endmodule

// File: rtl/smb_cfg_regbank.sv
module smb_cfg_regbank
    import smb_cfg_pkg::*;
#(
    parameter logic [6:0] ADDR_LO = 7'h68,
    parameter logic [6:0] ADDR_HI = 7'h6A
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             addr_sel,
    input  logic [1:0]       ss_strap,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    output logic [4:0]       rd_count,
    output logic [6:0]       my_addr,
    output cfg_out_t         cfg
);

    logic [1:0] strap_q;
    logic       sel_q;
    logic [7:0] store [NREG];
    logic [7:0] view  [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            strap_q <= strap_code(ss_strap);
            sel_q   <= addr_sel;
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [7:0] WM = reg_wmask(g);
        localparam logic [7:0] RV = reg_rst(g);

        always_ff @(posedge clk) begin
            if (rst) begin
                store[g] <= RV;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                store[g] <= (store[g] & ~WM) | (wr_data & WM);
            end
        end

        if (g == IDX_SS) begin : g_ss
            assign view[g] = {strap_q, store[g][5:0]};
        end else begin : g_plain
            assign view[g] = store[g];
        end
    end

    assign rd_data  = view[rd_idx];
    assign rd_count = view[IDX_CNT][4:0];
    assign my_addr  = sel_q ? ADDR_HI : ADDR_LO;

    always_comb begin
        cfg.dif_oe   = view[IDX_OE][3:2];
        cfg.amp      = view[IDX_SS][1:0];
        cfg.dif_slew = view[IDX_DSLW][2:1];
        cfg.ref_slew = view[IDX_REF][7:6];
        cfg.ref_wake = view[IDX_REF][5];
        cfg.ref_oe   = view[IDX_REF][4];
        cfg.ss_mode  = view[IDX_SS][5] ? view[IDX_SS][4:3] : strap_q;
    end

    // R8
    fields_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cfg));

    // R9
    strap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(strap_q));

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(my_addr));

endmodule

// File: rtl/smb_cfg_target.sv
module smb_cfg_target
    import smb_cfg_pkg::*;
#(
    parameter logic [6:0] ADDR_LO     = 7'h68,
    parameter logic [6:0] ADDR_HI     = 7'h6A,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic       addr_sel,
    input  logic [1:0] ss_strap,
    output logic [1:0] dif_oe,
    output logic [1:0] amp_sel,
    output logic [1:0] dif_slew,
    output logic [1:0] ref_slew,
    output logic       ref_wake_en,
    output logic       ref_oe,
    output logic [1:0] ss_mode
);

    bus_ev_t          ev;
    cfg_out_t         cfg;
    logic [7:0]       rd_data;
    logic [4:0]       rd_count;
    logic [6:0]       my_addr;

    phase_e           phase;
    kind_e            kind;
    logic [7:0]       sh;
    logic [3:0]       bitcnt;
    logic             got_byte;
    logic             rd_mode;
    logic             first_tx;
    logic             host_ack;
    logic [IDX_W-1:0] ptr;
    logic [7:0]       remaining;

    logic             byte_end;
    logic             byte_ok;
    logic             wr_en;
    logic             load_tx;
    logic [7:0]       tx_byte;

    smb_line_sync #(
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    smb_cfg_regbank #(
        .ADDR_LO (ADDR_LO),
        .ADDR_HI (ADDR_HI)
    ) i_bank (
        .clk      (clk),
        .rst      (rst),
        .addr_sel (addr_sel),
        .ss_strap (ss_strap),
        .wr_en    (wr_en),
        .wr_idx   (ptr),
        .wr_data  (sh),
        .rd_idx   (ptr),
        .rd_data  (rd_data),
        .rd_count (rd_count),
        .my_addr  (my_addr),
        .cfg      (cfg)
    );

    assign byte_end = (phase == PH_RX) && got_byte && ev.scl_fall;
    assign byte_ok  = (kind != BK_ADDR) || (sh[7:1] == my_addr);
    assign wr_en    = byte_end && (kind == BK_DATA) && (remaining != 8'd0);
    assign load_tx  = ev.scl_fall &&
                      (((phase == PH_ACK) && rd_mode) || ((phase == PH_HACK) && host_ack));
    assign tx_byte  = first_tx ? {3'b000, rd_count} : rd_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            kind      <= BK_ADDR;
            sh        <= '0;
            bitcnt    <= '0;
            got_byte  <= 1'b0;
            rd_mode   <= 1'b0;
            first_tx  <= 1'b0;
            host_ack  <= 1'b0;
            ptr       <= '0;
            remaining <= '0;
            sda_oe    <= 1'b0;
        end else if (ev.stop) begin
            phase    <= PH_IDLE;
            got_byte <= 1'b0;
            sda_oe   <= 1'b0;
        end else if (ev.start) begin
            phase    <= PH_RX;
            kind     <= BK_ADDR;
            bitcnt   <= '0;
            got_byte <= 1'b0;
            sda_oe   <= 1'b0;
        end else if (load_tx) begin
            phase  <= PH_TX;
            sh     <= tx_byte;
            sda_oe <= ~tx_byte[7];
            bitcnt <= '0;
            if (first_tx) begin
                first_tx <= 1'b0;
            end else begin
                ptr <= ptr + 1'b1;
            end
        end else begin
            unique case (phase)
                PH_RX: begin
                    if (ev.scl_rise && !got_byte) begin
                        sh     <= {sh[6:0], ev.sda};
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == 4'd7) begin
                            got_byte <= 1'b1;
                        end
                    end else if (byte_end) begin
                        got_byte <= 1'b0;
                        bitcnt   <= '0;
                        if (byte_ok) begin
                            phase  <= PH_ACK;
                            sda_oe <= 1'b1;
                        end else begin
                            phase <= PH_IDLE;
                        end
                        unique case (kind)
                            BK_ADDR: begin
                                rd_mode  <= sh[0];
                                first_tx <= sh[0];
                                kind     <= BK_INDEX;
                            end
                            BK_INDEX: begin
                                ptr  <= sh[IDX_W-1:0];
                                kind <= BK_COUNT;
                            end
                            BK_COUNT: begin
                                remaining <= sh;
                                kind      <= BK_DATA;
                            end
                            default: begin
                                if (wr_en) begin
                                    ptr       <= ptr + 1'b1;
                                    remaining <= remaining - 1'b1;
                                end
                            end
                        endcase
                    end
                end
                PH_ACK: begin
                    if (ev.scl_fall) begin
                        phase  <= PH_RX;
                        sda_oe <= 1'b0;
                    end
                end
                PH_TX: begin
                    if (ev.scl_rise) begin
                        bitcnt <= bitcnt + 1'b1;
                    end
                    if (ev.scl_fall) begin
                        if (bitcnt == 4'd8) begin
                            phase  <= PH_HACK;
                            sda_oe <= 1'b0;
                        end else begin
                            sh     <= {sh[6:0], 1'b0};
                            sda_oe <= ~sh[6];
                        end
                    end
                end
                PH_HACK: begin
                    if (ev.scl_rise) begin
                        host_ack <= ~ev.sda;
                    end
                    if (ev.scl_fall) begin
                        phase <= PH_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end

    assign dif_oe      = cfg.dif_oe;
    assign amp_sel     = cfg.amp;
    assign dif_slew    = cfg.dif_slew;
    assign ref_slew    = cfg.ref_slew;
    assign ref_wake_en = cfg.ref_wake;
    assign ref_oe      = cfg.ref_oe;
    assign ss_mode     = cfg.ss_mode;

    // R10
    oe_slot_chk: assert property (@(posedge clk) disable iff (rst)
        sda_oe |-> (phase == PH_ACK || phase == PH_TX));

    // R10
    oe_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> $past(ev.scl_fall || ev.start || ev.stop));

    // R3
    hack_release_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HACK) |-> !sda_oe);

    // R1
    write_mode_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !rd_mode);

endmodule

// File: tb/test_smb_cfg_target.sv
`timescale 1ns/1ps
module test_smb_cfg_target;

    localparam logic [6:0] A_LO = 7'h68;
    localparam logic [6:0] A_HI = 7'h6A;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_h = 1'b1;
    logic       addr_sel = 1'b0;
    logic [1:0] ss_strap = 2'd1;
    logic       sda_oe;
    logic [1:0] dif_oe, amp_sel, dif_slew, ref_slew, ss_mode;
    logic       ref_wake_en, ref_oe;
    logic       sda_line;

    int total = 0;
    int bad = 0;
    bit cmp_en = 0;
    logic [7:0] exp_reg [8];
    logic [7:0] wq [$];

    assign sda_line = sda_h & ~sda_oe;

    always #2 clk = ~clk;

    smb_cfg_target i_smb_cfg_target (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl),
        .sda_i       (sda_line),
        .sda_oe      (sda_oe),
        .addr_sel    (addr_sel),
        .ss_strap    (ss_strap),
        .dif_oe      (dif_oe),
        .amp_sel     (amp_sel),
        .dif_slew    (dif_slew),
        .ref_slew    (ref_slew),
        .ref_wake_en (ref_wake_en),
        .ref_oe      (ref_oe),
        .ss_mode     (ss_mode)
    );

    task automatic chk(input string req, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] wmask(input int i);
        case (i)
            0: return 8'h0C;
            1: return 8'h3B;
            2: return 8'h06;
            3: return 8'hF0;
            7: return 8'h1F;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [1:0] exp_ss();
        return exp_reg[1][5] ? exp_reg[1][4:3] : exp_reg[1][7:6];
    endfunction

    // field comparison against the model, every clock while the bus is idle
    always @(negedge clk) begin
        if (cmp_en && !rst) begin
            chk("R8 fields", {dif_oe, amp_sel, dif_slew, ref_slew, ref_wake_en, ref_oe},
                {exp_reg[0][3:2], exp_reg[1][1:0], exp_reg[2][2:1], exp_reg[3][7:4]});
            chk("R9 ss_mode", ss_mode, exp_ss());
        end
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic sel, input logic [1:0] st);
        int code;
        cmp_en = 0;
        rst = 1; addr_sel = sel; ss_strap = st; scl = 1; sda_h = 1;
        wt(6);
        rst = 0;
        code = (st == 2'd0) ? 0 : (st == 2'd1) ? 1 : 3;
        exp_reg[0] = 8'hFF; exp_reg[1] = {code[1:0], 6'b000110}; exp_reg[2] = 8'hFF;
        exp_reg[3] = 8'hDF; exp_reg[4] = 8'hFF; exp_reg[5] = 8'h01;
        exp_reg[6] = 8'h02; exp_reg[7] = 8'h08;
        wt(4);
        chk("R3 idle release", sda_oe, 0);
        cmp_en = 1;
    endtask

    task automatic start_c();
        cmp_en = 0;
        sda_h = 0; wt(8); scl = 0;
    endtask

    task automatic rstart_c();
        wt(4); sda_h = 1; wt(4); scl = 1; wt(8); sda_h = 0; wt(8); scl = 0;
    endtask

    task automatic stop_c();
        wt(4); sda_h = 0; wt(4); scl = 1; wt(8); sda_h = 1; wt(8);
    endtask

    task automatic put_bit(input logic v, output logic seen);
        wt(4); sda_h = v; wt(4); scl = 1; wt(4); seen = sda_line; wt(4); scl = 0;
    endtask

    task automatic get_bit(output logic v);
        wt(4); sda_h = 1; wt(4); scl = 1; wt(4); v = sda_line; wt(4); scl = 0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        int mism = 0;
        logic seen, a;
        for (int i = 7; i >= 0; i--) begin
            put_bit(b[i], seen);
            if (seen != b[i]) mism++;
        end
        chk("R10 host bits undisturbed", mism, 0);
        get_bit(a);
        ack = !a;
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic ack_it);
        logic v, seen;
        for (int i = 7; i >= 0; i--) begin
            get_bit(v);
            b[i] = v;
        end
        put_bit(!ack_it, seen);
    endtask

    task automatic do_write(input logic [6:0] addr, input logic [7:0] idx,
                            input logic [7:0] cnt, input logic exp_ack, input string req);
        logic a;
        start_c();
        send_byte({addr, 1'b0}, a);
        chk("R5 address ack", a, exp_ack);
        if (a) begin
            send_byte(idx, a);
            chk("R1 index ack", a, 1);
            send_byte(cnt, a);
            chk("R1 count ack", a, 1);
            for (int k = 0; k < wq.size(); k++) begin
                send_byte(wq[k], a);
                chk({req, " data ack"}, a, 1);
                if (k < cnt) begin
                    int i = (int'(idx) + k) % 8;
                    exp_reg[i] = (exp_reg[i] & ~wmask(i)) | (wq[k] & wmask(i));
                end
            end
        end
        stop_c();
        wt(4);
        cmp_en = 1;
    endtask

    task automatic do_read(input logic [6:0] addr, input logic [7:0] idx,
                           input int n, input logic exp_ack, input string req);
        logic a;
        logic [7:0] b;
        start_c();
        send_byte({addr, 1'b0}, a);
        chk("R5 address ack", a, exp_ack);
        if (a) begin
            send_byte(idx, a);
            chk("R2 index ack", a, 1);
            rstart_c();
            send_byte({addr, 1'b1}, a);
            chk("R2 read address ack", a, 1);
            recv_byte(b, 1'b1);
            chk("R2 count byte", b, {3'b000, exp_reg[7][4:0]});
            for (int k = 0; k < n; k++) begin
                recv_byte(b, k != n - 1);
                chk(req, b, exp_reg[(int'(idx) + k) % 8]);
            end
            wt(8);
            chk("R3 release after nack", sda_oe, 0);
        end
        stop_c();
        wt(4);
        cmp_en = 1;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R6: reset contents with address strap low, spread strap mid
        do_reset(1'b0, 2'd1);
        do_read(A_LO, 8'd0, 8, 1'b1, "R6 reset value");

        // R1 R7: block write of four registers with masked bits
        wq = {}; wq.push_back(8'h00); wq.push_back(8'h00);
        wq.push_back(8'h00); wq.push_back(8'h00);
        do_write(A_LO, 8'd0, 8'd4, 1'b1, "R1");
        do_read(A_LO, 8'd0, 8, 1'b1, "R7 readback");

        // R4: write that wraps from register 7 to register 0
        wq = {}; wq.push_back(8'hAA); wq.push_back(8'h0A); wq.push_back(8'h0C);
        do_write(A_LO, 8'd6, 8'd3, 1'b1, "R4");
        do_read(A_LO, 8'd6, 3, 1'b1, "R4 wrapped read");

        // R4: index byte above 7 selects register 3
        wq = {}; wq.push_back(8'hE0);
        do_write(A_LO, 8'h0B, 8'd1, 1'b1, "R4");
        chk("R8 ref_slew", ref_slew, 2'b11);

        // R1: bytes past the count are acked but not stored
        wq = {}; wq.push_back(8'h38); wq.push_back(8'hFF); wq.push_back(8'hFF);
        do_write(A_LO, 8'd1, 8'd1, 1'b1, "R1 excess");
        do_read(A_LO, 8'd1, 2, 1'b1, "R1 excess readback");
        chk("R9 software mode", ss_mode, 2'b11);

        // R9: software reserved code passes through
        wq = {}; wq.push_back(8'h30);
        do_write(A_LO, 8'd1, 8'd1, 1'b1, "R9");
        chk("R9 software mode", ss_mode, 2'b10);

        // R5: other address is not acknowledged and changes nothing
        wq = {}; wq.push_back(8'h00);
        do_write(A_HI, 8'd0, 8'd1, 1'b0, "R5");
        do_read(A_HI, 8'd0, 1, 1'b0, "R5");
        do_read(A_LO, 8'd0, 1, 1'b1, "R5 unchanged");

        // R2: programmed count byte
        wq = {}; wq.push_back(8'h03);
        do_write(A_LO, 8'd7, 8'd1, 1'b1, "R2");
        do_read(A_LO, 8'd0, 3, 1'b1, "R2 data");

        // R9: strap change after reset is ignored
        ss_strap = 2'd2;
        wq = {}; wq.push_back(8'h00);
        do_write(A_LO, 8'd1, 8'd1, 1'b1, "R9");
        chk("R9 strap held", ss_mode, 2'b01);
        do_read(A_LO, 8'd1, 1, 1'b1, "R9 readback");

        // R5 R6 R9: strap high, other address
        do_reset(1'b1, 2'd2);
        chk("R9 strap high", ss_mode, 2'b11);
        do_read(A_HI, 8'd0, 8, 1'b1, "R6 reset value");
        wq = {}; wq.push_back(8'h00);
        do_write(A_LO, 8'd0, 8'd1, 1'b0, "R5");
        wq = {}; wq.push_back(8'h04);
        do_write(A_HI, 8'd0, 8'd1, 1'b1, "R1");
        chk("R8 dif_oe", dif_oe, 2'b01);
        do_read(A_HI, 8'd7, 2, 1'b1, "R4 wrapped read");

        wt(10);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule